// File: doc/BRIEF.md
# Byte-Lane Peripheral Bridge

This block connects one 32-bit Wishbone classic master to a set of peripherals whose data ports are one byte wide. Each peripheral owns an address window given by a base and a mask at instantiation. The bridge compares the master address against every window and strobes the single matching peripheral. For a write it hands that peripheral the byte of the master's 32-bit write word that belongs to the addressed byte. For a read it places the returned byte in the matching lane of a 32-bit word, in big-endian order, and drives the other lanes to zero.

When no window matches, no peripheral sees the access. The bridge then answers the master with an error one cycle later, so the master cannot hang. Acknowledge and error from the selected peripheral go back to the master combinationally. The address and write-enable reach every peripheral unchanged, but only the selected one sees its cycle and strobe.

Top module: `byte_lane_bridge`

## Requirements
- R1: While mCyc and mStb are high and the address satisfies (mAdr & mask_k) == base_k, exactly slvCyc[k] and slvStb[k] are high. If several windows match, the lowest index wins. All other slave strobes stay low.
- R2: When mCyc and mStb are high and no window matches, no slave cycle or strobe is asserted and mAck stays low. mErr is high in the cycle after the first clock edge that sees the request.
- R3: slvDatW carries the byte of mDatW chosen by mAdr[1:0]: 0 gives bits [31:24], 1 gives [23:16], 2 gives [15:8] and 3 gives [7:0].
- R4: During a read, the selected slave's byte appears in mDatR at the lane given by the R3 mapping, and every other lane of mDatR is zero.
- R5: mAck and mErr follow the selected slave's ack and err in the same cycle. Ack or err from an unselected slave has no effect on the master.
- R6: After reset, with no request pending, mErr and mAck are low and no slave strobe is asserted.
- R7: slvAdr equals mAdr and slvWe equals mWe in every cycle.
- R8: The error for an unmatched request is a single-cycle pulse. It is low in the cycle after it was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mCyc | input | 1 | Master bus cycle |
| mStb | input | 1 | Master strobe |
| mWe | input | 1 | Master write enable |
| mAdr | input | ADDR_W | Master byte address |
| mDatW | input | 32 | Master write word |
| mDatR | output | 32 | Read word back to master |
| mAck | output | 1 | Acknowledge to master |
| mErr | output | 1 | Error to master |
| slvCyc | output | NUM_SLV | Per-slave bus cycle |
| slvStb | output | NUM_SLV | Per-slave strobe |
| slvWe | output | 1 | Write enable shared by all slaves |
| slvAdr | output | ADDR_W | Address shared by all slaves |
| slvDatW | output | 8 | Write byte shared by all slaves |
| slvDatR | input | 8*NUM_SLV | Read bytes, slave k in bits [8k+7:8k] |
| slvAck | input | NUM_SLV | Per-slave acknowledge |
| slvErr | input | NUM_SLV | Per-slave error |

## Verification
A wrong select shows up in the same cycle as a strobe on the wrong peripheral, or as read data from the wrong device. A lane fault shows up at once as a misplaced or non-zero byte in mDatR, or as the wrong byte on slvDatW. The only state is the miss-error flag. If it is wrong, mErr fails to rise one edge after an unmatched request, or it stays high past that edge. The bench drives an unselected peripheral's ack high to show that it cannot leak through to the master.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  typedef struct packed {
    logic       hit;      // some window matched the live request
    logic       missErr;  // registered error for an unmatched request
    logic [1:0] lane;     // byte index within the 32-bit word
  } bridgeCtrl_t;

  // Big-endian: byte index 0 lives in the top lane.
  function automatic int unsigned laneLsb(input logic [1:0] lane);
    return 32'd24 - 32'd8 * lane;
  endfunction

endpackage

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
  import bridge_pkg::*;
#(
  parameter int NUM_SLV = 4,
  parameter int ADDR_W  = 32,
  parameter logic [NUM_SLV*ADDR_W-1:0] SLV_BASE = '0,
  parameter logic [NUM_SLV*ADDR_W-1:0] SLV_MASK = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mCyc,
  input  logic               mStb,
  input  logic [ADDR_W-1:0]  mAdr,
  output logic [NUM_SLV-1:0] sel,
  output bridgeCtrl_t        ctrl,
  output logic [NUM_SLV-1:0] slvCyc,
  output logic [NUM_SLV-1:0] slvStb
);

  logic [NUM_SLV-1:0] match;
  logic               active;
  logic               anyHit;
  logic               missQ;

  assign active = mCyc & mStb;

  for (genvar g = 0; g < NUM_SLV; g++) begin : g_decode
    assign match[g] = ((mAdr & SLV_MASK[g*ADDR_W +: ADDR_W]) ==
                       SLV_BASE[g*ADDR_W +: ADDR_W]);
  end

  // Lowest index wins when windows overlap.
  always_comb begin
    sel    = '0;
    anyHit = 1'b0;
    for (int i = 0; i < NUM_SLV; i++) begin
      if (match[i] && !anyHit) begin
        sel[i] = 1'b1;
        anyHit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) missQ <= 1'b0;
    else     missQ <= active && !anyHit && !missQ;
  end

  assign slvCyc       = sel & {NUM_SLV{mCyc}};
  assign slvStb       = sel & {NUM_SLV{active}};
  assign ctrl.hit     = anyHit;
  assign ctrl.missErr = missQ;
  assign ctrl.lane    = mAdr[1:0];

  p_sel_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slvStb));

  p_miss_nostrobe_r2: assert property (@(posedge clk) disable iff (rst)
    (active && !anyHit) |-> (slvStb == '0 && slvCyc == '0));

  p_miss_err_r2: assert property (@(posedge clk) disable iff (rst)
    (active && !anyHit && !missQ) |=> missQ);

  p_err_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    missQ |=> !missQ);

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !mStb |-> (slvStb == '0));

endmodule

// File: rtl/bridge_dp.sv
module bridge_dp
  import bridge_pkg::*;
#(
  parameter int NUM_SLV = 4,
  parameter int ADDR_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SLV-1:0]   sel,
  input  bridgeCtrl_t          ctrl,
  input  logic [31:0]          mDatW,
  input  logic [8*NUM_SLV-1:0] slvDatR,
  input  logic [NUM_SLV-1:0]   slvAck,
  input  logic [NUM_SLV-1:0]   slvErr,
  output logic [7:0]           slvDatW,
  output logic [31:0]          mDatR,
  output logic                 mAck,
  output logic                 mErr
);

  logic [7:0] rdByte;

  assign slvDatW = mDatW[laneLsb(ctrl.lane) +: 8];

  always_comb begin
    rdByte = '0;
    for (int i = 0; i < NUM_SLV; i++) begin
      rdByte = rdByte | (slvDatR[8*i +: 8] & {8{sel[i]}});
    end
  end

  always_comb begin
    mDatR = '0;
    mDatR[laneLsb(ctrl.lane) +: 8] = rdByte;
  end

  assign mAck = |(slvAck & sel);
  assign mErr = |(slvErr & sel) | ctrl.missErr;

  p_lane0_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (ctrl.lane == 2'd0) |-> (mDatR[23:0] == 24'd0));

  p_lane3_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (ctrl.lane == 2'd3) |-> (mDatR[31:8] == 24'd0));

  p_ack_from_sel_r5: assert property (@(posedge clk) disable iff (rst)
    mAck |-> ctrl.hit);

  p_nohit_data_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !ctrl.hit |-> (mDatR == 32'd0));

endmodule

// File: rtl/byte_lane_bridge.sv
module byte_lane_bridge
  import bridge_pkg::*;
#(
  parameter int NUM_SLV = 4,
  parameter int ADDR_W  = 32,
  parameter logic [NUM_SLV*ADDR_W-1:0] SLV_BASE =
    {32'h9000_0300, 32'h9000_0200, 32'h9000_0100, 32'h9000_0000},
  parameter logic [NUM_SLV*ADDR_W-1:0] SLV_MASK =
    {4{32'hFFFF_FF00}}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mCyc,
  input  logic                 mStb,
  input  logic                 mWe,
  input  logic [ADDR_W-1:0]    mAdr,
  input  logic [31:0]          mDatW,
  output logic [31:0]          mDatR,
  output logic                 mAck,
  output logic                 mErr,
  output logic [NUM_SLV-1:0]   slvCyc,
  output logic [NUM_SLV-1:0]   slvStb,
  output logic                 slvWe,
  output logic [ADDR_W-1:0]    slvAdr,
  output logic [7:0]           slvDatW,
  input  logic [8*NUM_SLV-1:0] slvDatR,
  input  logic [NUM_SLV-1:0]   slvAck,
  input  logic [NUM_SLV-1:0]   slvErr
);

  logic [NUM_SLV-1:0] sel;
  bridgeCtrl_t        ctrl;

  assign slvWe  = mWe;
  assign slvAdr = mAdr;

  bridge_ctrl #(
    .NUM_SLV (NUM_SLV),
    .ADDR_W  (ADDR_W),
    .SLV_BASE(SLV_BASE),
    .SLV_MASK(SLV_MASK)
  ) i_ctrl (
    .clk   (clk),
    .rst   (rst),
    .mCyc  (mCyc),
    .mStb  (mStb),
    .mAdr  (mAdr),
    .sel   (sel),
    .ctrl  (ctrl),
    .slvCyc(slvCyc),
    .slvStb(slvStb)
  );

  bridge_dp #(
    .NUM_SLV(NUM_SLV),
    .ADDR_W (ADDR_W)
  ) i_dp (
    .clk    (clk),
    .rst    (rst),
    .sel    (sel),
    .ctrl   (ctrl),
    .mDatW  (mDatW),
    .slvDatR(slvDatR),
    .slvAck (slvAck),
    .slvErr (slvErr),
    .slvDatW(slvDatW),
    .mDatR  (mDatR),
    .mAck   (mAck),
    .mErr   (mErr)
  );

  p_fwd_r7: assert property (@(posedge clk) disable iff (rst)
    (slvAdr == mAdr) && (slvWe == mWe));

endmodule

// File: tb/test_byte_lane_bridge.sv
module test_byte_lane_bridge;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;

  typedef struct packed {
    logic        we;
    logic [31:0] adr;
    logic [31:0] wdat;
    logic [7:0]  expW;
    logic [31:0] expR;
  } vec_t;

  // Writes to each lane, then read-backs of the same locations.
  localparam vec_t VECS [8] = '{
    '{1'b1, 32'h9000_0110, 32'hA1B2_C3D4, 8'hA1, 32'h0},
    '{1'b1, 32'h9000_0221, 32'hA1B2_C3D4, 8'hB2, 32'h0},
    '{1'b1, 32'h9000_0332, 32'hA1B2_C3D4, 8'hC3, 32'h0},
    '{1'b1, 32'h9000_0043, 32'hA1B2_C3D4, 8'hD4, 32'h0},
    '{1'b0, 32'h9000_0110, 32'hFFFF_FFFF, 8'hFF, 32'hA100_0000},
    '{1'b0, 32'h9000_0221, 32'h0,         8'h00, 32'h00B2_0000},
    '{1'b0, 32'h9000_0332, 32'h0,         8'h00, 32'h0000_C300},
    '{1'b0, 32'h9000_0043, 32'h0,         8'h00, 32'h0000_00D4}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mCyc = 1'b0, mStb = 1'b0, mWe = 1'b0;
  logic [31:0] mAdr = '0, mDatW = '0;
  logic [31:0] mDatR;
  logic mAck, mErr;
  logic [NS-1:0] slvCyc, slvStb, slvAck, slvErr, forceAck;
  logic slvWe;
  logic [31:0] slvAdr;
  logic [7:0] slvDatW;
  logic [8*NS-1:0] slvDatR;
  logic [7:0] mem [NS][4];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_lane_bridge i_byte_lane_bridge (
    .clk(clk), .rst(rst), .mCyc(mCyc), .mStb(mStb), .mWe(mWe),
    .mAdr(mAdr), .mDatW(mDatW), .mDatR(mDatR), .mAck(mAck), .mErr(mErr),
    .slvCyc(slvCyc), .slvStb(slvStb), .slvWe(slvWe), .slvAdr(slvAdr),
    .slvDatW(slvDatW), .slvDatR(slvDatR), .slvAck(slvAck), .slvErr(slvErr)
  );

  // Peripheral models: zero-wait ack, 4-byte register file each.
  for (genvar s = 0; s < NS; s++) begin : g_slv
    assign slvAck[s] = slvStb[s] | forceAck[s];
    assign slvErr[s] = 1'b0;
    assign slvDatR[8*s +: 8] = mem[s][slvAdr[1:0]];
    always @(posedge clk)
      if (slvStb[s] && slvWe) mem[s][slvAdr[1:0]] <= slvDatW;
  end

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int slvOf(input logic [31:0] a);
    return int'(a[9:8]);
  endfunction

  // Drive at negedge, check the combinational response 1 time unit later.
  task automatic access(input logic we, input logic [31:0] a,
                        input logic [31:0] wd, input logic [7:0] expW,
                        input logic [31:0] expR);
    logic [NS-1:0] expSel;
    @(negedge clk);
    mCyc = 1'b1; mStb = 1'b1; mWe = we; mAdr = a; mDatW = wd;
    #1;
    expSel = NS'(1) << slvOf(a);
    check(slvStb == expSel && slvCyc == expSel, "R1 select", 32'(slvStb), 32'(expSel));
    check(mAck === 1'b1 && mErr === 1'b0, "R5 ack pass", {mAck, mErr}, 32'h2);
    check(slvAdr == a && slvWe == we, "R7 forward", slvAdr, a);
    if (we) check(slvDatW == expW, "R3 write byte", 32'(slvDatW), 32'(expW));
    else    check(mDatR == expR, "R4 read lane", mDatR, expR);
    @(negedge clk);
    mCyc = 1'b0; mStb = 1'b0; mWe = 1'b0;
  endtask

  initial begin
    forceAck = '0;
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < 4; k++)
        mem[s][k] = 8'(16 * s + k + 8'h40);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(mErr === 1'b0 && mAck === 1'b0 && slvStb == '0, "R6 reset state",
          {mErr, mAck, 2'b0, slvStb}, 32'h0);

    // Every lane of every slave, read.
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < 4; k++)
        access(1'b0, 32'h9000_0000 + 32'(s) * 32'h100 + 32'h80 + 32'(k),
               32'h0, 8'h0,
               32'(8'(16 * s + k + 8'h40)) << (24 - 8 * k));

    // Table: writes into each lane, then read-back.
    for (int i = 0; i < 8; i++)
      access(VECS[i].we, VECS[i].adr, VECS[i].wdat, VECS[i].expW, VECS[i].expR);

    // Unmapped address, with an unselected slave driving ack (R2, R5, R8).
    @(negedge clk);
    forceAck = 4'b0010;
    mCyc = 1'b1; mStb = 1'b1; mWe = 1'b0; mAdr = 32'h1234_5602;
    #1;
    check(slvStb == '0 && slvCyc == '0, "R2 no slave", 32'(slvStb), 32'h0);
    check(mAck === 1'b0, "R5 stray ack ignored", 32'(mAck), 32'h0);
    check(mErr === 1'b0, "R2 err not yet", 32'(mErr), 32'h0);
    @(posedge clk); #1;
    check(mErr === 1'b1, "R2 err next cycle", 32'(mErr), 32'h1);
    check(mAck === 1'b0, "R2 no ack on miss", 32'(mAck), 32'h0);
    @(posedge clk); #1;
    check(mErr === 1'b0, "R8 err one cycle", 32'(mErr), 32'h0);
    @(negedge clk);
    mCyc = 1'b0; mStb = 1'b0; forceAck = '0;
    @(posedge clk); #1;
    check(mErr === 1'b0 && slvStb == '0, "R6 idle after miss", {mErr, slvStb}, 32'h0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule